// File: doc/BRIEF.md
# Three-Wire Command/Data Serial Port

This block is the slave side of a three-wire serial link (a transfer-enable line, a serial clock and a single data line) that gives a host access to a pair of 32-bit time counters. The three pins are oversampled by a faster system clock. The block finds the edges of the enable line and of the serial clock in that domain and acts on them. Each transfer opens with a one-byte command. The command names a counter, chooses between a read and a write, can ask for either counter or both to be zeroed, and can instead load a three-bit oscillator trim value.

On a read, the selected counter is copied into a snapshot register as soon as the command byte is complete. The snapshot is then shifted out over the next 32 serial clock periods. On a write, 32 bits are shifted into a holding register, and a single load strobe hands the whole word to the counter core on the last bit. Clear requests are held until the host drops the enable line. The counter core itself lives outside this block. It connects through snapshot, load, clear and trim strobes.

Top module: `wire3_port`

## Requirements
- R1: After reset, `ser_oe` is 0, every strobe output is 0, and `trim_val` holds `TRIM_INIT` (default 3'b011).
- R2: A transfer opens on a rising edge of `xfer_en`. The first 8 rising edges of `ser_clk` shift in the command byte, least-significant bit first. In that byte, bit 7 picks the continuous counter, bit 6 picks the power-gated counter, and bit 0 picks a read (1) or a write (0).
- R3: On a read, the selected counter input is captured, with one `snap_stb` pulse, on the 8th command bit. The captured value leaves on `ser_dout` least-significant bit first. The first bit goes out on the `ser_clk` falling edge after that command bit. Changes to the counter input after the capture do not alter the word read.
- R4: `ser_oe` is 1 only during a read, only while `ser_clk` is low, and only for 32 bits. It returns to 0 while `ser_clk` is high and when `xfer_en` falls.
- R5: On a write, 32 data bits are shifted in least-significant bit first. On the 32nd data rising edge, exactly one `load_cont` or `load_gated` pulse is issued, carrying the word on `load_data`. A write cut short by `xfer_en` falling issues no load.
- R6: After the 32nd data bit, further `ser_clk` edges have no effect until `xfer_en` goes low and high again.
- R7: If command bits 7 and 6 are both 1, bits 5:3 go to `trim_val` with one `trim_we` pulse. The rest of the transfer then causes no load, no snapshot and no drive.
- R8: Command bit 2 requests a clear of the continuous counter and bit 1 a clear of the power-gated counter. Each clear is a one-cycle `clr_cont` / `clr_gated` pulse issued when `xfer_en` falls, and only if all 8 command bits were received.
- R9: While `pwr_ok` is 0, the port ignores all pin activity: no drive, no strobes, no trim change. Any transfer in progress is abandoned.
- R10: If neither bit 7 nor bit 6 is set, the data clocks that follow cause no load, no snapshot and no drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supply good; port disabled while low |
| xfer_en | input | 1 | Transfer enable pin, high during a transfer |
| ser_clk | input | 1 | Serial clock pin |
| ser_din | input | 1 | Serial data input pin |
| cont_val | input | DATA_W | Current value of the continuous counter |
| gated_val | input | DATA_W | Current value of the power-gated counter |
| ser_dout | output | 1 | Serial data output |
| ser_oe | output | 1 | Output enable for the data pin |
| snap_stb | output | 1 | Pulse: a counter value was captured for reading |
| load_cont | output | 1 | Pulse: load `load_data` into the continuous counter |
| load_gated | output | 1 | Pulse: load `load_data` into the power-gated counter |
| load_data | output | DATA_W | Word written by the host |
| clr_cont | output | 1 | Pulse: zero the continuous counter |
| clr_gated | output | 1 | Pulse: zero the power-gated counter |
| trim_we | output | 1 | Pulse: `trim_val` was updated |
| trim_val | output | 3 | Oscillator trim setting |

## Verification
The bench changes the counter input right after the command byte. A design that captured the counter late, or read it live while shifting, would return the changed value. It clocks extra bits after a full write and cuts another write short. A design that counted bits wrongly would then issue a second load, a load with shifted data, or a load for an incomplete word. It drops the enable line partway through a command that carries clear requests. A design that acted on the partial byte would zero a counter it was never fully told to clear. It also checks the drive enable against each serial clock phase, during trim-only and no-counter transfers, and with supply-good low. In each case a careless design would drive the shared data line at the wrong time.

// File: rtl/w3p_pkg.sv
package w3p_pkg;

  localparam int CMD_W  = 8;
  localparam int TRIM_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_WRITE,
    ST_HOLD
  } port_state_t;

  // Field order follows bit positions 7 down to 0 of the command byte.
  typedef struct packed {
    logic              sel_cont;
    logic              sel_gated;
    logic [TRIM_W-1:0] trim;
    logic              clr_cont;
    logic              clr_gated;
    logic              rd;
  } cmd_t;

endpackage

// File: rtl/w3p_sync.sv
module w3p_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], pin};
  end

  assign lvl = chain[STAGES-1];

endmodule

// File: rtl/w3p_edge.sv
module w3p_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

endmodule

// File: rtl/w3p_ctrl.sv
module w3p_ctrl
  import w3p_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [TRIM_W-1:0] TRIM_INIT = 3'b011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_ok,
  input  logic              en_rise,
  input  logic              en_fall,
  input  logic              ck_rise,
  input  logic              ck_fall,
  input  logic              din,
  // datapath controls (same-cycle)
  output logic              snap_en,
  output logic              snap_cont,
  output logic              out_step,
  output logic              in_step,
  // registered outputs
  output logic              oe,
  output logic              snap_stb,
  output logic              load_cont,
  output logic              load_gated,
  output logic              clr_cont,
  output logic              clr_gated,
  output logic              trim_we,
  output logic [TRIM_W-1:0] trim_val
);

  localparam int             CNT_W    = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] DAT_FULL = CNT_W'(DATA_W);

  port_state_t        state;
  logic [CMD_W-2:0]   cmd_sr;
  logic [CNT_W-1:0]   bit_cnt;
  logic               pend_clr_c;
  logic               pend_clr_g;
  logic               sel_cont_q;

  logic [CMD_W-1:0]   cmd_next;
  cmd_t               dec;
  logic               live;
  logic               cmd_last;
  logic               one_sel;
  logic               commit;

  assign cmd_next = {din, cmd_sr};
  assign dec      = cmd_t'(cmd_next);
  assign live     = pwr_ok && !en_fall;
  assign one_sel  = dec.sel_cont ^ dec.sel_gated;
  assign cmd_last = live && (state == ST_CMD) && ck_rise && (bit_cnt == CMD_LAST);

  assign snap_en   = cmd_last && one_sel && dec.rd;
  assign snap_cont = dec.sel_cont;
  assign out_step  = live && (state == ST_READ) && ck_fall && (bit_cnt != DAT_FULL);
  assign in_step   = live && (state == ST_WRITE) && ck_rise;
  assign commit    = in_step && (bit_cnt == DAT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cmd_sr     <= '0;
      bit_cnt    <= '0;
      pend_clr_c <= 1'b0;
      pend_clr_g <= 1'b0;
      sel_cont_q <= 1'b0;
      oe         <= 1'b0;
      snap_stb   <= 1'b0;
      load_cont  <= 1'b0;
      load_gated <= 1'b0;
      clr_cont   <= 1'b0;
      clr_gated  <= 1'b0;
      trim_we    <= 1'b0;
      trim_val   <= TRIM_INIT;
    end else begin
      snap_stb   <= 1'b0;
      load_cont  <= 1'b0;
      load_gated <= 1'b0;
      clr_cont   <= 1'b0;
      clr_gated  <= 1'b0;
      trim_we    <= 1'b0;

      if (!pwr_ok) begin
        state      <= ST_IDLE;
        oe         <= 1'b0;
        pend_clr_c <= 1'b0;
        pend_clr_g <= 1'b0;
      end else if (en_fall) begin
        state      <= ST_IDLE;
        oe         <= 1'b0;
        clr_cont   <= pend_clr_c;
        clr_gated  <= pend_clr_g;
        pend_clr_c <= 1'b0;
        pend_clr_g <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (en_rise) begin
              state   <= ST_CMD;
              bit_cnt <= '0;
            end
          end
          ST_CMD: begin
            if (ck_rise) begin
              cmd_sr  <= cmd_next[CMD_W-1:1];
              bit_cnt <= bit_cnt + 1'b1;
              if (cmd_last) begin
                bit_cnt    <= '0;
                pend_clr_c <= dec.clr_cont;
                pend_clr_g <= dec.clr_gated;
                sel_cont_q <= dec.sel_cont;
                if (dec.sel_cont && dec.sel_gated) begin
                  trim_we  <= 1'b1;
                  trim_val <= dec.trim;
                  state    <= ST_HOLD;
                end else if (one_sel) begin
                  snap_stb <= dec.rd;
                  state    <= dec.rd ? ST_READ : ST_WRITE;
                end else begin
                  state <= ST_HOLD;
                end
              end
            end
          end
          ST_READ: begin
            if (out_step) begin
              oe      <= 1'b1;
              bit_cnt <= bit_cnt + 1'b1;
            end
            if (ck_rise) begin
              oe <= 1'b0;
              if (bit_cnt == DAT_FULL) state <= ST_HOLD;
            end
          end
          ST_WRITE: begin
            if (in_step) begin
              bit_cnt <= bit_cnt + 1'b1;
              if (commit) begin
                load_cont  <= sel_cont_q;
                load_gated <= !sel_cont_q;
                state      <= ST_HOLD;
              end
            end
          end
          ST_HOLD: begin
            oe <= 1'b0;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/w3p_datapath.sv
module w3p_datapath #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snap_en,
  input  logic              snap_cont,
  input  logic              out_step,
  input  logic              in_step,
  input  logic              din,
  input  logic [DATA_W-1:0] cont_val,
  input  logic [DATA_W-1:0] gated_val,
  output logic              dout,
  output logic [DATA_W-1:0] wbuf
);

  logic [DATA_W-1:0] snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= '0;
      dout <= 1'b0;
      wbuf <= '0;
    end else begin
      if (snap_en)       snap <= snap_cont ? cont_val : gated_val;
      else if (out_step) snap <= {1'b0, snap[DATA_W-1:1]};
      if (out_step)      dout <= snap[0];
      if (in_step)       wbuf <= {din, wbuf[DATA_W-1:1]};
    end
  end

endmodule

// File: rtl/wire3_port.sv
module wire3_port
  import w3p_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                SYNC_STAGES = 2,
  parameter logic [TRIM_W-1:0] TRIM_INIT   = 3'b011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_ok,
  input  logic              xfer_en,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic [DATA_W-1:0] cont_val,
  input  logic [DATA_W-1:0] gated_val,
  output logic              ser_dout,
  output logic              ser_oe,
  output logic              snap_stb,
  output logic              load_cont,
  output logic              load_gated,
  output logic [DATA_W-1:0] load_data,
  output logic              clr_cont,
  output logic              clr_gated,
  output logic              trim_we,
  output logic [TRIM_W-1:0] trim_val
);

  localparam int N_PINS  = 3;
  localparam int N_EDGES = 2;

  logic [N_PINS-1:0]  pin_raw;
  logic [N_PINS-1:0]  pin_lvl;
  logic [N_EDGES-1:0] edge_rise;
  logic [N_EDGES-1:0] edge_fall;

  logic en_lvl, ck_lvl, din_lvl;
  logic snap_en, snap_cont, out_step, in_step;

  assign pin_raw = {ser_din, ser_clk, xfer_en};

  for (genvar gi = 0; gi < N_PINS; gi++) begin : g_sync
    w3p_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk (clk),
      .rst (rst),
      .pin (pin_raw[gi]),
      .lvl (pin_lvl[gi])
    );
  end

  for (genvar ge = 0; ge < N_EDGES; ge++) begin : g_edge
    w3p_edge i_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  (pin_lvl[ge]),
      .rise (edge_rise[ge]),
      .fall (edge_fall[ge])
    );
  end

  assign en_lvl  = pin_lvl[0];
  assign ck_lvl  = pin_lvl[1];
  assign din_lvl = pin_lvl[2];

  w3p_ctrl #(.DATA_W(DATA_W), .TRIM_INIT(TRIM_INIT)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .pwr_ok     (pwr_ok),
    .en_rise    (edge_rise[0]),
    .en_fall    (edge_fall[0]),
    .ck_rise    (edge_rise[1]),
    .ck_fall    (edge_fall[1]),
    .din        (din_lvl),
    .snap_en    (snap_en),
    .snap_cont  (snap_cont),
    .out_step   (out_step),
    .in_step    (in_step),
    .oe         (ser_oe),
    .snap_stb   (snap_stb),
    .load_cont  (load_cont),
    .load_gated (load_gated),
    .clr_cont   (clr_cont),
    .clr_gated  (clr_gated),
    .trim_we    (trim_we),
    .trim_val   (trim_val)
  );

  w3p_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rst       (rst),
    .snap_en   (snap_en),
    .snap_cont (snap_cont),
    .out_step  (out_step),
    .in_step   (in_step),
    .din       (din_lvl),
    .cont_val  (cont_val),
    .gated_val (gated_val),
    .dout      (ser_dout),
    .wbuf      (load_data)
  );

endmodule

// File: rtl/w3p_checker.sv
module w3p_checker (
  input logic       clk,
  input logic       rst,
  input logic       pwr_ok,
  input logic       en_lvl,
  input logic       ck_lvl,
  input logic       ser_oe,
  input logic       load_cont,
  input logic       load_gated,
  input logic       clr_cont,
  input logic       clr_gated,
  input logic       trim_we,
  input logic [2:0] trim_val
);

  // R4
  oe_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
    ser_oe |-> !$past(ck_lvl));

  // R9
  oe_off_no_power_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> !ser_oe);

  // R5
  single_load_chk: assert property (@(posedge clk) disable iff (rst)
    !(load_cont && load_gated));

  // R5
  load_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    (load_cont || load_gated) |-> ($past(en_lvl) && $past(pwr_ok)));

  // R8
  clear_on_release_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_cont || clr_gated) |-> !$past(en_lvl));

  // R8
  clear_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    clr_cont |=> !clr_cont);

  // R7
  trim_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !trim_we |-> $stable(trim_val));

  // R7
  trim_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    trim_we |-> $past(en_lvl));

endmodule

bind wire3_port w3p_checker i_w3p_checker (
  .clk        (clk),
  .rst        (rst),
  .pwr_ok     (pwr_ok),
  .en_lvl     (en_lvl),
  .ck_lvl     (ck_lvl),
  .ser_oe     (ser_oe),
  .load_cont  (load_cont),
  .load_gated (load_gated),
  .clr_cont   (clr_cont),
  .clr_gated  (clr_gated),
  .trim_we    (trim_we),
  .trim_val   (trim_val)
);

// File: tb/test_wire3_port.sv
`timescale 1ns/1ps
module test_wire3_port;

  localparam int DW = 32;
  localparam int HP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pwr_ok = 1'b1;
  logic          xfer_en = 1'b0;
  logic          ser_clk = 1'b1;
  logic          ser_din = 1'b0;
  logic [DW-1:0] cont_val = '0;
  logic [DW-1:0] gated_val = '0;
  logic          ser_dout, ser_oe, snap_stb, load_cont, load_gated;
  logic [DW-1:0] load_data;
  logic          clr_cont, clr_gated, trim_we;
  logic [2:0]    trim_val;

  int n_tests = 0;
  int n_fail  = 0;
  int n_snap = 0, n_ldc = 0, n_ldg = 0, n_clc = 0, n_clg = 0, n_trim = 0;
  logic [DW-1:0] last_ld;

  always #2.5 clk = ~clk;

  wire3_port i_wire3_port (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .xfer_en(xfer_en),
    .ser_clk(ser_clk), .ser_din(ser_din), .cont_val(cont_val),
    .gated_val(gated_val), .ser_dout(ser_dout), .ser_oe(ser_oe),
    .snap_stb(snap_stb), .load_cont(load_cont), .load_gated(load_gated),
    .load_data(load_data), .clr_cont(clr_cont), .clr_gated(clr_gated),
    .trim_we(trim_we), .trim_val(trim_val)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (snap_stb)   n_snap++;
      if (load_cont)  begin n_ldc++; last_ld = load_data; end
      if (load_gated) begin n_ldg++; last_ld = load_data; end
      if (clr_cont)   n_clc++;
      if (clr_gated)  n_clg++;
      if (trim_we)    n_trim++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic xfer_start();
    xfer_en = 1'b1;
    wait_cyc(HP);
  endtask

  task automatic xfer_stop();
    xfer_en = 1'b0;
    wait_cyc(2 * HP);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      ser_clk = 1'b0;
      ser_din = v[i];
      wait_cyc(HP);
      ser_clk = 1'b1;
      wait_cyc(HP);
    end
  endtask

  // Clocks n bits out; counts drive-enable samples that differ from expectation.
  task automatic read_bits(input int n, input bit drive, output logic [31:0] val, output int bad);
    val = '0;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      ser_clk = 1'b0;
      wait_cyc(HP);
      if (ser_oe !== drive) bad++;
      val[i] = ser_dout;
      ser_clk = 1'b1;
      wait_cyc(HP);
      if (ser_oe !== 1'b0) bad++;
    end
  endtask

  task automatic t_reset();
    chk("R1 oe", 32'(ser_oe), 0);
    chk("R1 trim", 32'(trim_val), 32'd3);
    chk("R1 strobes", 32'(n_snap + n_ldc + n_ldg + n_clc + n_clg + n_trim), 0);
  endtask

  task automatic t_read_cont();
    logic [31:0] v; int bad;
    int s0 = n_snap;
    cont_val = 32'hA5C3_0F71;
    xfer_start();
    send_bits(32'h81, 8);
    cont_val = 32'h1111_2222;
    read_bits(32, 1'b1, v, bad);
    chk("R3 read cont value", v, 32'hA5C3_0F71);
    chk("R4 oe phases", 32'(bad), 0);
    chk("R3 one snapshot", 32'(n_snap - s0), 1);
    read_bits(3, 1'b0, v, bad);
    chk("R6 no drive after 32", 32'(bad), 0);
    xfer_stop();
    chk("R4 oe after end", 32'(ser_oe), 0);
  endtask

  task automatic t_read_gated();
    logic [31:0] v; int bad;
    cont_val  = 32'hFFFF_FFFF;
    gated_val = 32'h0BAD_F00D;
    xfer_start();
    send_bits(32'h41, 8);
    read_bits(32, 1'b1, v, bad);
    xfer_stop();
    chk("R2 read gated value", v, 32'h0BAD_F00D);
    chk("R4 oe phases gated", 32'(bad), 0);
  endtask

  task automatic t_read_abort();
    logic [31:0] v; int bad;
    xfer_start();
    send_bits(32'h81, 8);
    read_bits(10, 1'b1, v, bad);
    ser_clk = 1'b0;
    wait_cyc(HP);
    xfer_en = 1'b0;
    wait_cyc(HP);
    chk("R4 oe drops when enable falls", 32'(ser_oe), 0);
    ser_clk = 1'b1;
    wait_cyc(2 * HP);
  endtask

  task automatic t_write();
    int c0 = n_ldc, g0 = n_ldg;
    xfer_start();
    send_bits(32'h80, 8);
    send_bits(32'h1234_5678, 32);
    chk("R5 one cont load", 32'(n_ldc - c0), 1);
    chk("R5 load data", last_ld, 32'h1234_5678);
    send_bits(32'hFFFF_FFFF, 6);
    xfer_stop();
    chk("R6 extra clocks ignored", 32'(n_ldc - c0), 1);
    chk("R2 gated untouched", 32'(n_ldg - g0), 0);
    xfer_start();
    send_bits(32'h40, 8);
    send_bits(32'hCAFE_0001, 32);
    xfer_stop();
    chk("R2 gated load", 32'(n_ldg - g0), 1);
    chk("R5 gated data", last_ld, 32'hCAFE_0001);
  endtask

  task automatic t_write_abort();
    int c0 = n_ldc;
    xfer_start();
    send_bits(32'h80, 8);
    send_bits(32'h0000_FFFF, 20);
    xfer_stop();
    xfer_start();
    send_bits(32'h0, 12);
    xfer_stop();
    chk("R5 aborted write no load", 32'(n_ldc - c0), 0);
  endtask

  task automatic t_trim();
    logic [31:0] v; int bad;
    int t0 = n_trim, s0 = n_snap, l0 = n_ldc + n_ldg;
    xfer_start();
    send_bits(32'hE9, 8);
    read_bits(32, 1'b0, v, bad);
    xfer_stop();
    chk("R7 trim value", 32'(trim_val), 32'd5);
    chk("R7 one trim strobe", 32'(n_trim - t0), 1);
    chk("R7 no drive", 32'(bad), 0);
    chk("R7 no snap or load", 32'(n_snap - s0 + n_ldc + n_ldg - l0), 0);
  endtask

  task automatic t_none_sel();
    logic [31:0] v; int bad;
    int s0 = n_snap, l0 = n_ldc + n_ldg;
    xfer_start();
    send_bits(32'h01, 8);
    read_bits(32, 1'b0, v, bad);
    xfer_stop();
    xfer_start();
    send_bits(32'h00, 8);
    send_bits(32'hDEAD_BEEF, 32);
    xfer_stop();
    chk("R10 no drive", 32'(bad), 0);
    chk("R10 no snap or load", 32'(n_snap - s0 + n_ldc + n_ldg - l0), 0);
  endtask

  task automatic t_clear();
    logic [31:0] v; int bad;
    int c0 = n_clc, g0 = n_clg;
    xfer_start();
    send_bits(32'h85, 8);
    read_bits(32, 1'b1, v, bad);
    chk("R8 no clear before release", 32'(n_clc - c0), 0);
    xfer_stop();
    chk("R8 cont clear", 32'(n_clc - c0), 1);
    chk("R8 gated not cleared", 32'(n_clg - g0), 0);
    xfer_start();
    send_bits(32'h06, 8);
    xfer_stop();
    chk("R8 both clears", 32'((n_clc - c0) * 16 + (n_clg - g0)), 32'h21);
    xfer_start();
    send_bits(32'h06, 5);
    xfer_stop();
    chk("R8 partial command no clear", 32'((n_clc - c0) * 16 + (n_clg - g0)), 32'h21);
  endtask

  task automatic t_power();
    logic [31:0] v; int bad;
    int all0 = n_snap + n_ldc + n_ldg + n_clc + n_clg + n_trim;
    pwr_ok = 1'b0;
    wait_cyc(2);
    xfer_start();
    send_bits(32'h87, 8);
    read_bits(32, 1'b0, v, bad);
    xfer_stop();
    xfer_start();
    send_bits(32'hC6, 8);
    xfer_stop();
    chk("R9 no drive", 32'(bad), 0);
    chk("R9 no strobes", 32'(n_snap + n_ldc + n_ldg + n_clc + n_clg + n_trim - all0), 0);
    chk("R9 trim kept", 32'(trim_val), 32'd5);
    // power lost mid-write
    pwr_ok = 1'b1;
    wait_cyc(2);
    xfer_start();
    send_bits(32'h80, 8);
    send_bits(32'h5555_5555, 16);
    pwr_ok = 1'b0;
    wait_cyc(4);
    pwr_ok = 1'b1;
    send_bits(32'h5555_5555, 16);
    xfer_stop();
    chk("R9 write abandoned", 32'(n_ldc + n_ldg + n_snap + n_clc + n_clg + n_trim - all0), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(5);
    t_reset();
    t_read_cont();
    t_read_gated();
    t_read_abort();
    t_write();
    t_write_abort();
    t_trim();
    t_none_sel();
    t_clear();
    t_power();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule